// File: doc/BRIEF.md
# Big-Endian Bus Access Sequencer

This block sits between a processor's load/store unit and a narrow synchronous memory bus. It takes one operand request of byte, word or long-word size. It issues the number of bus beats that the request needs, waits for memory to acknowledge each beat, and hands the assembled read operand back with a one-cycle done pulse. The bus width is fixed at elaboration to 16 or 8 bits. Memory is byte addressed and big-endian: the more significant byte of any pair lives at the lower, even address, and multi-beat operands are moved at rising addresses with the most significant part first.

On the 16-bit bus, two lane strobes select the upper half (even byte) and the lower half (odd byte) of the data path. A word or long-word request must start at an even address. An odd start address is rejected with an error pulse and produces no bus activity. The address is 24 bits wide and carries the full byte address of every beat.

Top module: `be_bus_sequencer`

## Requirements
- R1: While reset is low, and after its release until a request is accepted, `busy`, `done`, `align_err`, `mem_valid`, `mem_we`, `mem_strb_hi` and `mem_strb_lo` are all low.
- R2: On the 16-bit bus a byte request (size code 0) makes one beat at the request address. At an even address only `mem_strb_hi` is high, and the byte travels on bits [15:8] of the data bus. At an odd address only `mem_strb_lo` is high, and the byte travels on bits [7:0]. The unused half of the write bus is zero.
- R3: On the 16-bit bus a word request (size code 1) makes one beat at its even address with both strobes high and `req_wdata[15:0]` on the write bus.
- R4: On the 16-bit bus a long request (size code 2; code 3 behaves the same) makes two beats. The first is at address n carrying `req_wdata[31:16]`, the second at n+2 carrying `req_wdata[15:0]`. On a read, the first beat's word becomes the upper half of the result.
- R5: On the 8-bit bus every beat moves one byte with `mem_strb_hi` high and `mem_strb_lo` low. A word is two beats at n and n+1, and a long is four beats at n to n+3, the most significant byte first.
- R6: A word or long request (size 1, 2 or 3) accepted while idle with `req_addr[0]` = 1 raises `align_err` for exactly the next cycle. It issues no beat and gives no `done`.
- R7: While a beat is offered and `mem_ready` is low, the address, both strobes, `mem_we` and the write data stay unchanged in the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the clock edge at which the last beat is acknowledged. For a read, `rdata` then holds the operand in big-endian order, with the bits above the operand size zero. It keeps that value until the next request is accepted.
- R9: A request presented while `busy` is high is ignored: it adds no beat and starts no later transfer.
- R10: A request presented in the cycle in which `done` is high is accepted, and its first beat is offered in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request, taken when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_addr | input | ADDR_W (24) | Byte address of the operand |
| req_wdata | input | OP_W (32) | Store operand, right aligned |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misalignment pulse |
| rdata | output | OP_W (32) | Assembled load operand, zero-extended |
| mem_valid | output | 1 | A beat is offered on the bus |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W (24) | Byte address of the beat |
| mem_strb_hi | output | 1 | Upper (even byte) lane strobe |
| mem_strb_lo | output | 1 | Lower (odd byte) lane strobe, 16-bit bus only |
| mem_wdata | output | BUS_W (16) | Beat write data |
| mem_rdata | input | BUS_W (16) | Beat read data |
| mem_ready | input | 1 | Memory acknowledges the current beat |

## Verification
Two events can fall in one cycle here: the completion of one transfer (the done pulse, with its read result) and the acceptance of the next request. The bench provokes this by raising a new request in exactly the cycle `done` is seen. It then judges that the first result is intact at that moment, that the new beat appears in the next cycle, and that the second operand comes back correctly. A second overlap, a request arriving while beats are still in flight, is provoked under memory wait states and judged by the beat log held in the memory model.

// File: rtl/be_seq_pkg.sv
package be_seq_pkg;

  typedef enum logic {ST_IDLE, ST_BEAT} seq_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;

  // operand length in bytes for a size code (code 3 counts as long)
  function automatic logic [2:0] op_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // multibyte operands must begin at an even byte
  function automatic logic is_misaligned(input logic [1:0] sz, input logic a0);
    return (sz != SZ_BYTE) && a0;
  endfunction

  // byte offset of beat idx from the operand start
  function automatic logic [2:0] beat_offset(input logic [1:0] idx, input logic wide);
    return wide ? {idx, 1'b0} : {1'b0, idx};
  endfunction

  // right-shift that brings beat idx of the operand to bit 0
  function automatic logic [5:0] beat_shift(input logic [2:0] nb, input logic [1:0] idx,
                                            input logic wide);
    logic [2:0] rem;
    rem = nb - 3'd1 - {1'b0, idx};
    return wide ? {rem[1:0], 4'b0000} : {rem, 3'b000};
  endfunction

endpackage

// File: rtl/be_beat_plan.sv
module be_beat_plan
  import be_seq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic [1:0] sz,
  input  logic       a0,
  output logic [2:0] nb,
  output logic       wide,
  output logic       mis
);

  assign mis = is_misaligned(sz, a0);

  generate
    if (BUS_W == 16) begin : g_bus16
      always_comb begin
        wide = (sz != SZ_BYTE);
        nb   = wide ? (op_bytes(sz) >> 1) : 3'd1;
      end
    end else begin : g_bus8
      always_comb begin
        wide = 1'b0;
        nb   = op_bytes(sz);
      end
    end
  endgenerate

endmodule

// File: rtl/be_lane_drive.sv
module be_lane_drive
  import be_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24,
  parameter int OP_W   = 32
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] base,
  input  logic [OP_W-1:0]   op,
  input  logic [2:0]        nb,
  input  logic [1:0]        idx,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic              strb_hi,
  output logic              strb_lo,
  output logic [BUS_W-1:0]  bus_wd
);

  logic [BUS_W-1:0] part;

  assign addr = base + ADDR_W'(beat_offset(idx, wide));
  assign part = BUS_W'(op >> beat_shift(nb, idx, wide));

  generate
    if (BUS_W == 16) begin : g_bus16
      always_comb begin
        strb_hi = active & (wide | ~addr[0]);
        strb_lo = active & (wide | addr[0]);
        if (wide)         bus_wd = part;
        else if (addr[0]) bus_wd = {8'h00, part[7:0]};
        else              bus_wd = {part[7:0], 8'h00};
      end
    end else begin : g_bus8
      always_comb begin
        strb_hi = active;
        strb_lo = 1'b0;
        bus_wd  = part;
      end
    end
  endgenerate

endmodule

// File: rtl/be_read_collect.sv
module be_read_collect #(
  parameter int BUS_W = 16,
  parameter int OP_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             capture,
  input  logic             wide,
  input  logic             a0,
  input  logic [BUS_W-1:0] bus_rd,
  output logic [OP_W-1:0]  acc
);

  logic [OP_W-1:0] nxt;

  generate
    if (BUS_W == 16) begin : g_bus16
      always_comb begin
        if (wide) nxt = {acc[OP_W-17:0], bus_rd};
        else      nxt = {acc[OP_W-9:0], (a0 ? bus_rd[7:0] : bus_rd[15:8])};
      end
    end else begin : g_bus8
      always_comb nxt = {acc[OP_W-9:0], bus_rd};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (clear)   acc <= '0;
    else if (capture) acc <= nxt;
  end

endmodule

// File: rtl/be_bus_sequencer.sv
module be_bus_sequencer
  import be_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24,
  parameter int OP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OP_W-1:0]   req_wdata,
  output logic              busy,
  output logic              done,
  output logic              align_err,
  output logic [OP_W-1:0]   rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_strb_hi,
  output logic              mem_strb_lo,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic [BUS_W-1:0]  mem_rdata,
  input  logic              mem_ready
);

  seq_st_e           st;
  logic [ADDR_W-1:0] a_q;
  logic [OP_W-1:0]   wd_q;
  logic              we_q;
  logic [2:0]        nb_q;
  logic              wide_q;
  logic [1:0]        idx_q;
  logic              done_q;
  logic              err_q;

  logic [2:0] plan_nb;
  logic       plan_wide;
  logic       plan_mis;

  // named events shared with the checker
  logic idle, accept, reject, beat_ack, last_beat, last_ack;

  be_beat_plan #(.BUS_W(BUS_W)) u_plan (
    .sz   (req_size),
    .a0   (req_addr[0]),
    .nb   (plan_nb),
    .wide (plan_wide),
    .mis  (plan_mis)
  );

  assign idle      = (st == ST_IDLE);
  assign accept    = idle & req_valid & ~plan_mis;
  assign reject    = idle & req_valid & plan_mis;
  assign beat_ack  = (st == ST_BEAT) & mem_ready;
  assign last_beat = ({1'b0, idx_q} == (nb_q - 3'd1));
  assign last_ack  = beat_ack & last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      nb_q   <= 3'd1;
      wide_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= last_ack;
      err_q  <= reject;
      if (accept) begin
        st     <= ST_BEAT;
        a_q    <= req_addr;
        wd_q   <= req_wdata;
        we_q   <= req_write;
        nb_q   <= plan_nb;
        wide_q <= plan_wide;
        idx_q  <= '0;
      end else if (last_ack) begin
        st <= ST_IDLE;
      end else if (beat_ack) begin
        idx_q <= idx_q + 2'd1;
      end
    end
  end

  assign busy      = (st == ST_BEAT);
  assign mem_valid = busy;
  assign mem_we    = busy & we_q;
  assign done      = done_q;
  assign align_err = err_q;

  be_lane_drive #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_lane (
    .active  (busy),
    .base    (a_q),
    .op      (wd_q),
    .nb      (nb_q),
    .idx     (idx_q),
    .wide    (wide_q),
    .addr    (mem_addr),
    .strb_hi (mem_strb_hi),
    .strb_lo (mem_strb_lo),
    .bus_wd  (mem_wdata)
  );

  be_read_collect #(.BUS_W(BUS_W), .OP_W(OP_W)) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (beat_ack & ~we_q),
    .wide    (wide_q),
    .a0      (mem_addr[0]),
    .bus_rd  (mem_rdata),
    .acc     (rdata)
  );

endmodule

// File: rtl/be_seq_checker.sv
module be_seq_checker #(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              align_err,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_strb_hi,
  input logic              mem_strb_lo,
  input logic [BUS_W-1:0]  mem_wdata,
  input logic              accept,
  input logic              last_ack
);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !mem_strb_hi && !mem_strb_lo && !mem_we);

  p_both_lanes_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_strb_hi && mem_strb_lo |-> !mem_addr[0]);

  p_accept_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_valid && busy);

  p_narrow_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (BUS_W == 8) && mem_valid |-> mem_strb_hi && !mem_strb_lo);

  p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_valid && !done);

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> !align_err);

  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_strb_hi)
      && $stable(mem_strb_lo) && $stable(mem_we) && $stable(mem_wdata));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> done && !mem_valid);

  p_done_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid && mem_ready));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind be_bus_sequencer be_seq_checker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_be_bus_sequencer.sv
`timescale 1ns/1ps

module sim_mem #(parameter int BW = 16) (
  input  logic        clk,
  input  logic        clr,
  input  logic        valid,
  input  logic        we,
  input  logic        hi,
  input  logic        lo,
  input  logic [23:0] addr,
  input  logic [15:0] wd,
  input  logic [1:0]  wt,
  output logic        ready,
  output logic [15:0] rd
);
  logic [7:0]  mem   [256];
  logic [23:0] log_a [8];
  logic        log_h [8];
  logic        log_l [8];
  logic [15:0] log_w [8];
  int nlog = 0;
  int cnt  = 0;

  always @(posedge clk) begin
    if (clr) begin
      for (int k = 0; k < 256; k++) mem[k] <= 8'(k * 13 + 7);
      nlog  <= 0;
      cnt   <= 0;
      ready <= 1'b0;
      rd    <= '0;
    end else if (ready) begin
      ready <= 1'b0;
      cnt   <= 0;
    end else if (valid) begin
      if (cnt >= int'(wt)) begin
        ready <= 1'b1;
        cnt   <= 0;
        if (nlog < 8) begin
          log_a[nlog] <= addr;
          log_h[nlog] <= hi;
          log_l[nlog] <= lo;
          log_w[nlog] <= wd;
        end
        nlog <= nlog + 1;
        if (BW == 16) begin
          rd <= {mem[{addr[7:1], 1'b0}], mem[{addr[7:1], 1'b1}]};
          if (we && hi) mem[{addr[7:1], 1'b0}] <= wd[15:8];
          if (we && lo) mem[{addr[7:1], 1'b1}] <= wd[7:0];
        end else begin
          rd <= {8'h00, mem[addr[7:0]]};
          if (we) mem[addr[7:0]] <= wd[7:0];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module sim_be_bus_sequencer;

  typedef struct packed {
    logic        b8;
    logic        wr;
    logic [1:0]  sz;
    logic [23:0] ad;
    logic [31:0] wd;
    logic [1:0]  wt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd0, 24'hA30040, 32'h0000_0000, 2'd0},
    '{1'b0, 1'b0, 2'd0, 24'hA30041, 32'h0000_0000, 2'd1},
    '{1'b0, 1'b1, 2'd0, 24'h000052, 32'hFFFF_FFC3, 2'd0},
    '{1'b0, 1'b1, 2'd0, 24'h000053, 32'h1111_113C, 2'd2},
    '{1'b0, 1'b0, 2'd1, 24'h7F0060, 32'h0000_0000, 2'd1},
    '{1'b0, 1'b1, 2'd1, 24'h000064, 32'h7777_BEEF, 2'd0},
    '{1'b0, 1'b0, 2'd2, 24'h000070, 32'h0000_0000, 2'd2},
    '{1'b0, 1'b1, 2'd2, 24'h000078, 32'h1234_5678, 2'd1},
    '{1'b1, 1'b0, 2'd0, 24'h000081, 32'h0000_0000, 2'd0},
    '{1'b1, 1'b1, 2'd0, 24'h000086, 32'h0000_00A5, 2'd1},
    '{1'b1, 1'b0, 2'd1, 24'h000090, 32'h0000_0000, 2'd2},
    '{1'b1, 1'b1, 2'd1, 24'h000096, 32'h0000_CAFE, 2'd0},
    '{1'b1, 1'b0, 2'd2, 24'h0000A0, 32'h0000_0000, 2'd1},
    '{1'b1, 1'b1, 2'd2, 24'h0000A8, 32'h89AB_CDEF, 2'd3},
    '{1'b0, 1'b0, 2'd3, 24'h0000B4, 32'h0000_0000, 2'd0},
    '{1'b1, 1'b0, 2'd3, 24'h0000C0, 32'h0000_0000, 2'd0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, clr;
  logic        req_write;
  logic [1:0]  req_size, wt;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        v16, v8;

  logic        b16, d16, e16, mv16, we16, h16, l16, rdy16;
  logic [31:0] r16;
  logic [23:0] a16;
  logic [15:0] wd16, rd16;

  logic        b8, d8, e8, mv8, we8, h8, l8, rdy8;
  logic [31:0] r8;
  logic [23:0] a8;
  logic [7:0]  wd8;
  logic [15:0] rd8;

  int checks = 0;
  int errors = 0;

  be_bus_sequencer #(.BUS_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v16), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(b16), .done(d16), .align_err(e16),
    .rdata(r16), .mem_valid(mv16), .mem_we(we16), .mem_addr(a16), .mem_strb_hi(h16),
    .mem_strb_lo(l16), .mem_wdata(wd16), .mem_rdata(rd16), .mem_ready(rdy16));

  be_bus_sequencer #(.BUS_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(b8), .done(d8), .align_err(e8),
    .rdata(r8), .mem_valid(mv8), .mem_we(we8), .mem_addr(a8), .mem_strb_hi(h8),
    .mem_strb_lo(l8), .mem_wdata(wd8), .mem_rdata(rd8[7:0]), .mem_ready(rdy8));

  sim_mem #(.BW(16)) m16 (.clk(clk), .clr(clr), .valid(mv16), .we(we16), .hi(h16), .lo(l16),
    .addr(a16), .wd(wd16), .wt(wt), .ready(rdy16), .rd(rd16));

  sim_mem #(.BW(8)) m8 (.clk(clk), .clr(clr), .valid(mv8), .we(we8), .hi(h8), .lo(l8),
    .addr(a8), .wd({8'h00, wd8}), .wt(wt), .ready(rdy8), .rd(rd8));

  function automatic logic [7:0] pat(input logic [23:0] a);
    return 8'(int'(a[7:0]) * 13 + 7);
  endfunction

  function automatic logic [7:0] opb(input logic [31:0] w, input int nbytes, input int k);
    return 8'(w >> (8 * (nbytes - 1 - k)));
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.b8) return "R5";
    case (v.sz)
      2'd0:    return "R2";
      2'd1:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic get_log(input bit n8, input int i, output logic [23:0] a,
                         output logic h, output logic l, output logic [15:0] w);
    if (n8) begin a = m8.log_a[i];  h = m8.log_h[i];  l = m8.log_l[i];  w = m8.log_w[i];  end
    else    begin a = m16.log_a[i]; h = m16.log_h[i]; l = m16.log_l[i]; w = m16.log_w[i]; end
  endtask

  task automatic clear_mem();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic issue(input bit n8, input bit wr, input logic [1:0] sz,
                       input logic [23:0] ad, input logic [31:0] wd);
    @(negedge clk);
    req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
    if (n8) v8 = 1'b1; else v16 = 1'b1;
    @(negedge clk);
    v8 = 1'b0; v16 = 1'b0;
  endtask

  task automatic wait_done(input bit n8, output bit got);
    got = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (n8 ? d8 : d16) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit got;
    int nbytes, nb, cnt;
    bit wide;
    logic [23:0] la, ea;
    logic lh, ll, eh, el;
    logic [15:0] lw, ew;
    logic [31:0] exp, act;
    string tg;
    tg = tag_of(v);
    clear_mem();
    wt = v.wt;
    issue(v.b8, v.wr, v.sz, v.ad, v.wd);
    wait_done(v.b8, got);
    chk(got, "R8", "done seen", 32'(got), 32'd1);
    nbytes = (v.sz == 2'd0) ? 1 : (v.sz == 2'd1) ? 2 : 4;
    wide   = !v.b8 && (v.sz != 2'd0);
    nb     = wide ? nbytes / 2 : nbytes;
    cnt    = v.b8 ? m8.nlog : m16.nlog;
    chk(cnt == nb, tg, "beat count", 32'(cnt), 32'(nb));
    for (int i = 0; i < nb && i < cnt; i++) begin
      get_log(v.b8, i, la, lh, ll, lw);
      ea = v.ad + 24'(wide ? 2 * i : i);
      if (v.b8)      begin eh = 1'b1; el = 1'b0; end
      else if (wide) begin eh = 1'b1; el = 1'b1; end
      else           begin eh = ~ea[0]; el = ea[0]; end
      chk(la == ea, tg, "beat address", 32'(la), 32'(ea));
      chk({lh, ll} == {eh, el}, tg, "beat strobes", 32'({lh, ll}), 32'({eh, el}));
      if (v.wr) begin
        if (v.b8)      ew = {8'h00, opb(v.wd, nbytes, i)};
        else if (wide) ew = {opb(v.wd, nbytes, 2 * i), opb(v.wd, nbytes, 2 * i + 1)};
        else           ew = ea[0] ? {8'h00, opb(v.wd, 1, 0)} : {opb(v.wd, 1, 0), 8'h00};
        chk(lw == ew, tg, "beat write data", 32'(lw), 32'(ew));
      end
    end
    if (!v.wr) begin
      exp = '0;
      for (int k = 0; k < nbytes; k++) exp = (exp << 8) | 32'(pat(v.ad + 24'(k)));
      act = v.b8 ? r8 : r16;
      chk(act == exp, "R8", "assembled read data", act, exp);
    end else begin
      for (int k = 0; k < nbytes; k++) begin
        logic [7:0] mb;
        mb = v.b8 ? m8.mem[8'(v.ad + 24'(k))] : m16.mem[8'(v.ad + 24'(k))];
        chk(mb == opb(v.wd, nbytes, k), tg, "stored byte", 32'(mb), 32'(opb(v.wd, nbytes, k)));
      end
      if (!v.b8 && v.sz == 2'd0) begin
        logic [7:0] nbr;
        nbr = m16.mem[8'(v.ad ^ 24'd1)];
        chk(nbr == pat(v.ad ^ 24'd1), "R2", "other lane untouched", 32'(nbr), 32'(pat(v.ad ^ 24'd1)));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a_hold;
    logic [1:0]  s_hold;
    bit got;
    rst_n = 1'b0; clr = 1'b1; v16 = 1'b0; v8 = 1'b0; wt = 2'd0;
    req_write = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk({b16, d16, e16, mv16, we16, h16, l16} == 7'b0, "R1", "u0 outputs in reset",
        32'({b16, d16, e16, mv16, we16, h16, l16}), 32'd0);
    clr = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk({b16, d16, e16, mv16, we16, h16, l16} == 7'b0, "R1", "u0 outputs after reset",
        32'({b16, d16, e16, mv16, we16, h16, l16}), 32'd0);
    chk({b8, d8, e8, mv8, we8, h8, l8} == 7'b0, "R1", "u1 outputs after reset",
        32'({b8, d8, e8, mv8, we8, h8, l8}), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R6: misaligned word on the wide bus, misaligned long on the narrow bus
    clear_mem();
    issue(1'b0, 1'b0, 2'd1, 24'h000031, 32'h0);
    chk(e16 == 1'b1, "R6", "align_err raised", 32'(e16), 32'd1);
    chk(mv16 == 1'b0, "R6", "no beat on error", 32'(mv16), 32'd0);
    @(negedge clk);
    chk(e16 == 1'b0, "R6", "align_err one cycle", 32'(e16), 32'd0);
    issue(1'b1, 1'b1, 2'd2, 24'h000043, 32'hDEAD_BEEF);
    chk(e8 == 1'b1, "R6", "align_err raised 8-bit", 32'(e8), 32'd1);
    repeat (4) @(negedge clk);
    chk(m16.nlog == 0 && m8.nlog == 0, "R6", "no beats issued", 32'(m16.nlog + m8.nlog), 32'd0);
    chk(d16 == 1'b0 && d8 == 1'b0 && b16 == 1'b0 && b8 == 1'b0, "R6", "no done or busy",
        32'({d16, d8, b16, b8}), 32'd0);

    // R7 and R9: hold under wait states, request during busy is dropped
    clear_mem();
    wt = 2'd3;
    issue(1'b0, 1'b0, 2'd2, 24'h000010, 32'h0);
    a_hold = a16;
    s_hold = {h16, l16};
    req_size = 2'd0; req_addr = 24'h000051; v16 = 1'b1;
    @(negedge clk);
    v16 = 1'b0;
    chk(a16 == a_hold && {h16, l16} == s_hold && mv16, "R7", "beat held while not ready",
        32'(a16), 32'(a_hold));
    wait_done(1'b0, got);
    chk(got, "R9", "first transfer completes", 32'(got), 32'd1);
    repeat (5) @(negedge clk);
    chk(m16.nlog == 2, "R9", "beat count unchanged by busy request", 32'(m16.nlog), 32'd2);
    chk(m16.log_a[1] == 24'h000012, "R9", "second beat is the original", 32'(m16.log_a[1]), 32'h12);
    chk(b16 == 1'b0, "R9", "no later transfer started", 32'(b16), 32'd0);

    // R10: new request in the same cycle as done
    clear_mem();
    wt = 2'd0;
    issue(1'b0, 1'b0, 2'd2, 24'h000020, 32'h0);
    wait_done(1'b0, got);
    chk(r16 == {pat(24'h20), pat(24'h21), pat(24'h22), pat(24'h23)}, "R8", "first result at done",
        r16, {pat(24'h20), pat(24'h21), pat(24'h22), pat(24'h23)});
    req_write = 1'b0; req_size = 2'd0; req_addr = 24'h000025; v16 = 1'b1;
    @(negedge clk);
    v16 = 1'b0;
    chk(mv16 == 1'b1 && a16 == 24'h000025, "R10", "beat follows done-cycle request",
        32'(a16), 32'h25);
    wait_done(1'b0, got);
    chk(got && r16 == 32'(pat(24'h25)), "R10", "second result", r16, 32'(pat(24'h25)));
    chk(m16.nlog == 3, "R10", "total beats", 32'(m16.nlog), 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule